// File: doc/BRIEF.md
# Program and Data Memory Map Decoder

This block sits between the processor core and its memories and decides, for every code fetch and every external-data (MOVX) access, which memory answers. Code can come from internal code RAM, a boot ROM or external program memory. Data can come from internal extended RAM (whose visible size is selectable), from code RAM when the code-RAM write override is on, or from external data memory. Each access is presented with its address and kind. One clock later the block returns a one-hot target select and an external-bus request.

The block also keeps the state that steers the map. It latches the external-access strap while reset is held, and it holds a four-bit configuration register with the boot-ROM enable, the code-RAM override, the external-data bit and the extended-RAM size bit. From the latched strap it derives the reset vector. It also holds a small pointer-select register whose increment flips the select bit and leaves the flag bit unchanged. It raises an error flag when a fetch is routed off-chip while the external bus is unavailable.

Top module: `memmap_decoder`

## Requirements
- R1: `ext_pin_i` is captured on every clock while `rst_n` is low and is then held. Changes after reset release have no effect. `reset_vec_o` is F800h when the captured value is 1 and 0000h when it is 0.
- R2: With the captured strap at 0, every fetch (kind 0) selects external program memory (`code_sel_o` = 3'b100), whatever the address.
- R3: With the captured strap at 1, fetches to 0000h–7FFFh select code RAM (`code_sel_o` = 3'b001).
- R4: With the captured strap at 1, fetches at 8000h and above select boot ROM (3'b010) when the boot-enable bit (`cfg_wdata_i[3]`) is 1, and external memory (3'b100) when it is 0.
- R5: Reset sets the configuration register to boot-enable 1 and all other bits to 0. Code-RAM override is bit 2, external-data is bit 1, size is bit 0.
- R6: With override 0, external-data 0 and size 0, a 16-bit-pointer MOVX (kind 2) below 0100h selects extended RAM (`data_sel_o` = 3'b001). At 0100h and above it selects external memory (3'b100).
- R7: With the size bit at 1, the internal range grows to 0000h–01FFh, and 0200h and above roll over to external memory.
- R8: An 8-bit-pointer MOVX (kind 1) decodes only `acc_addr_i[7:0]`. With override 0 and external-data 0 it always selects extended RAM.
- R9: With external-data 1 and override 0, every MOVX of either kind selects external memory.
- R10: With the override at 1, every MOVX selects code RAM (3'b010), even when external-data is 1.
- R11: `ext_req_o` is 1 exactly when the registered target is external. Internal targets leave it at 0.
- R12: `err_o` is 1 when a fetch selects external memory while `ext_bus_en_i` is 0. It stays 0 for internal fetches and for all MOVX.
- R13: `ptr_o` bit 0 is the pointer select, bit 1 always reads 0 and bit 2 is a flag. `ptr_inc_i` adds one to the register, which toggles bit 0 and keeps bit 2.
- R14: Outputs are registered one cycle after the access. They are all zero after reset and for idle cycles (`acc_valid_i` = 0 or kind 3). At most one select bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 1 | External-access strap, captured during reset |
| ext_bus_en_i | input | 1 | External bus available |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 4 | {boot_en, cram_map, ext_data, size_big} |
| ptr_we_i | input | 1 | Pointer-select register write strobe |
| ptr_wdata_i | input | 3 | {flag, -, select} |
| ptr_inc_i | input | 1 | Increment pointer-select register |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_kind_i | input | 2 | 0 fetch, 1 MOVX 8-bit pointer, 2 MOVX 16-bit pointer, 3 none |
| acc_addr_i | input | 16 | Access address |
| code_sel_o | output | 3 | One-hot {external, boot ROM, code RAM} |
| data_sel_o | output | 3 | One-hot {external, code RAM, extended RAM} |
| ext_req_o | output | 1 | External bus request |
| err_o | output | 1 | Fetch to external memory with bus disabled |
| ptr_o | output | 3 | Pointer-select register |
| reset_vec_o | output | 16 | Execution start address |

## Verification
Fetches are applied on both sides of 7FFFh with boot enable on and off, and again after a reset with the strap low. These separate the code-RAM, boot-ROM and external decodes, and show that the strap alone takes priority. MOVX accesses are applied just below and just above both size limits, once with each pointer width. This tells an honest size compare from one that wraps or ignores the size bit, and shows whether the 8-bit pointer's upper byte is masked. The override and external-data bits are then set together to confirm which one wins. The bus-enable input is lowered for internal fetches, external fetches and external MOVX, so that the error flag is seen to depend only on off-chip fetches.

// File: rtl/memmap_pkg.sv
// Shared types for the memory map decoder.
// Assumes: select vectors are 3 bits, one bit per target.
package memmap_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH  = 2'd0,
        KIND_MOVX8  = 2'd1,
        KIND_MOVX16 = 2'd2,
        KIND_IDLE   = 2'd3
    } acc_kind_e;

    // Bit 3 boot_en, bit 2 cram_map, bit 1 ext_data, bit 0 size_big
    typedef struct packed {
        logic boot_en;
        logic cram_map;
        logic ext_data;
        logic size_big;
    } mm_cfg_t;

    localparam int CODE_CRAM = 0;
    localparam int CODE_BOOT = 1;
    localparam int CODE_EXT  = 2;
    localparam int DATA_XRAM = 0;
    localparam int DATA_CRAM = 1;
    localparam int DATA_EXT  = 2;
    localparam int SEL_W     = 3;

endpackage

// File: rtl/memmap_ctrl.sv
// Control state for the memory map: the external-access strap latch,
// the configuration register, the pointer-select register and the
// reset vector. Assumes the strap is stable during reset.
module memmap_ctrl
    import memmap_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] BOOT_VEC = 16'hF800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_i,
    input  logic              cfg_we_i,
    input  logic [3:0]        cfg_wdata_i,
    input  logic              ptr_we_i,
    input  logic [2:0]        ptr_wdata_i,
    input  logic              ptr_inc_i,
    output logic              ea_o,
    output mm_cfg_t           cfg_o,
    output logic [2:0]        ptr_o,
    output logic [ADDR_W-1:0] reset_vec_o
);

    localparam mm_cfg_t CFG_RST = '{boot_en: 1'b1, cram_map: 1'b0,
                                    ext_data: 1'b0, size_big: 1'b0};

    logic        ea_q;
    mm_cfg_t     cfg_q;
    logic [2:0]  ptr_q;
    logic [2:0]  ptr_sum;

    // Capture the strap while reset is held, keep it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) ea_q <= ext_pin_i;
    end

    // Configuration register with boot enable set at reset
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= CFG_RST;
        else if (cfg_we_i) cfg_q <= mm_cfg_t'(cfg_wdata_i);
    end

    // Increment value; bit 1 is held at 0 so carries stop there
    always_comb ptr_sum = ptr_q + 3'd1;

    // Pointer-select register, write beats increment
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr_q <= 3'b000;
        else if (ptr_we_i)  ptr_q <= {ptr_wdata_i[2], 1'b0, ptr_wdata_i[0]};
        else if (ptr_inc_i) ptr_q <= {ptr_sum[2], 1'b0, ptr_sum[0]};
    end

    assign ea_o        = ea_q;
    assign cfg_o       = cfg_q;
    assign ptr_o       = ptr_q;
    assign reset_vec_o = ea_q ? BOOT_VEC[ADDR_W-1:0] : '0;

    assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ea_q));

    assert_inc_toggle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc_i && !ptr_we_i) |=>
        (ptr_q[0] != $past(ptr_q[0])) && (ptr_q[2] == $past(ptr_q[2])));

    assert_cfg_reset_R5: assert property (@(posedge clk)
        !rst_n |=> cfg_q.boot_en && !cfg_q.cram_map && !cfg_q.ext_data && !cfg_q.size_big);

endmodule

// File: rtl/memmap_code_dec.sv
// Combinational code-fetch target decode. Assumes code RAM starts at 0
// and boot ROM covers everything above it.
module memmap_code_dec
    import memmap_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CRAM_SIZE = 32768
) (
    input  logic              ea_i,
    input  logic              boot_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SEL_W-1:0]  sel_o
);

    localparam logic [ADDR_W:0] CRAM_LIM = (ADDR_W+1)'(CRAM_SIZE);

    // Strap low sends everything off-chip; else split at code RAM top
    always_comb begin
        sel_o = '0;
        if (!ea_i)                          sel_o[CODE_EXT]  = 1'b1;
        else if ({1'b0, addr_i} < CRAM_LIM) sel_o[CODE_CRAM] = 1'b1;
        else if (boot_en_i)                 sel_o[CODE_BOOT] = 1'b1;
        else                                sel_o[CODE_EXT]  = 1'b1;
    end

endmodule

// File: rtl/memmap_data_dec.sv
// Combinational MOVX target decode. Assumes the 8-bit pointer form
// carries its address in the low byte only.
module memmap_data_dec
    import memmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int XRAM_SMALL = 256,
    parameter int XRAM_BIG   = 512
) (
    input  logic              short_ptr_i,
    input  mm_cfg_t           cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SEL_W-1:0]  sel_o
);

    localparam logic [ADDR_W:0] LIM_SMALL = (ADDR_W+1)'(XRAM_SMALL);
    localparam logic [ADDR_W:0] LIM_BIG   = (ADDR_W+1)'(XRAM_BIG);

    logic [ADDR_W:0] eff_addr;
    logic [ADDR_W:0] limit;

    // Effective address and the visible internal size
    always_comb begin
        eff_addr = short_ptr_i ? {{(ADDR_W-7){1'b0}}, addr_i[7:0]} : {1'b0, addr_i};
        limit    = cfg_i.size_big ? LIM_BIG : LIM_SMALL;
    end

    // Override first, then external bit, then size compare
    always_comb begin
        sel_o = '0;
        if (cfg_i.cram_map)       sel_o[DATA_CRAM] = 1'b1;
        else if (cfg_i.ext_data)  sel_o[DATA_EXT]  = 1'b1;
        else if (eff_addr < limit) sel_o[DATA_XRAM] = 1'b1;
        else                      sel_o[DATA_EXT]  = 1'b1;
    end

endmodule

// File: rtl/memmap_decoder.sv
// Top of the memory map decoder: routes each access to one target and
// registers the result for one cycle. Assumes one access per cycle.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          CRAM_SIZE  = 32768,
    parameter int          XRAM_SMALL = 256,
    parameter int          XRAM_BIG   = 512,
    parameter logic [15:0] BOOT_VEC   = 16'hF800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_i,
    input  logic              ext_bus_en_i,
    input  logic              cfg_we_i,
    input  logic [3:0]        cfg_wdata_i,
    input  logic              ptr_we_i,
    input  logic [2:0]        ptr_wdata_i,
    input  logic              ptr_inc_i,
    input  logic              acc_valid_i,
    input  logic [1:0]        acc_kind_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output logic [2:0]        code_sel_o,
    output logic [2:0]        data_sel_o,
    output logic              ext_req_o,
    output logic              err_o,
    output logic [2:0]        ptr_o,
    output logic [ADDR_W-1:0] reset_vec_o
);

    logic             ea;
    mm_cfg_t          cfg;
    logic [SEL_W-1:0] code_raw, data_raw;
    logic [SEL_W-1:0] code_nxt, data_nxt;
    logic             is_fetch, is_movx;
    logic             ext_nxt, err_nxt;
    logic [SEL_W-1:0] code_q, data_q;
    logic             ext_q, err_q;

    memmap_ctrl #(.ADDR_W(ADDR_W), .BOOT_VEC(BOOT_VEC)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .ptr_we_i(ptr_we_i), .ptr_wdata_i(ptr_wdata_i), .ptr_inc_i(ptr_inc_i),
        .ea_o(ea), .cfg_o(cfg), .ptr_o(ptr_o), .reset_vec_o(reset_vec_o)
    );

    memmap_code_dec #(.ADDR_W(ADDR_W), .CRAM_SIZE(CRAM_SIZE)) i_code (
        .ea_i(ea), .boot_en_i(cfg.boot_en), .addr_i(acc_addr_i), .sel_o(code_raw)
    );

    memmap_data_dec #(.ADDR_W(ADDR_W), .XRAM_SMALL(XRAM_SMALL), .XRAM_BIG(XRAM_BIG)) i_data (
        .short_ptr_i(acc_kind_i == KIND_MOVX8), .cfg_i(cfg),
        .addr_i(acc_addr_i), .sel_o(data_raw)
    );

    // Qualify decodes by access kind and form the bus request and error
    always_comb begin
        is_fetch = acc_valid_i && (acc_kind_i == KIND_FETCH);
        is_movx  = acc_valid_i && ((acc_kind_i == KIND_MOVX8) || (acc_kind_i == KIND_MOVX16));
        code_nxt = is_fetch ? code_raw : '0;
        data_nxt = is_movx  ? data_raw : '0;
        ext_nxt  = code_nxt[CODE_EXT] | data_nxt[DATA_EXT];
        err_nxt  = code_nxt[CODE_EXT] & ~ext_bus_en_i;
    end

    // Output register, cleared at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            data_q <= '0;
            ext_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            code_q <= code_nxt;
            data_q <= data_nxt;
            ext_q  <= ext_nxt;
            err_q  <= err_nxt;
        end
    end

    assign code_sel_o = code_q;
    assign data_sel_o = data_q;
    assign ext_req_o  = ext_q;
    assign err_o      = err_q;

    assert_one_target_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_sel_o, data_sel_o}));

    assert_internal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (code_sel_o[CODE_CRAM] | code_sel_o[CODE_BOOT] |
         data_sel_o[DATA_XRAM] | data_sel_o[DATA_CRAM]) |-> !ext_req_o);

    assert_strap_low_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_kind_i == KIND_FETCH && !ea) |=> code_sel_o == 3'b100);

    assert_override_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && (acc_kind_i == KIND_MOVX8 || acc_kind_i == KIND_MOVX16) && cfg.cram_map)
        |=> data_sel_o == 3'b010);

    assert_err_is_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> code_sel_o[CODE_EXT]);

    assert_idle_zero_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> (code_sel_o == 3'b000) && (data_sel_o == 3'b000) && !err_o);

endmodule

// File: tb/test_memmap_decoder.sv
module test_memmap_decoder;

    typedef struct {
        logic [2:0] code;
        logic [2:0] data;
        logic       req;
        logic       err;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b1;
    logic        bus_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = '0;
    logic        ptr_we = 1'b0;
    logic [2:0]  ptr_wdata = '0;
    logic        ptr_inc = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd3;
    logic [15:0] acc_addr = '0;
    logic [2:0]  code_sel, data_sel, ptr_val;
    logic        ext_req, err;
    logic [15:0] reset_vec;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    memmap_decoder i_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .ext_bus_en_i(bus_en),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata), .ptr_inc_i(ptr_inc),
        .acc_valid_i(acc_valid), .acc_kind_i(acc_kind), .acc_addr_i(acc_addr),
        .code_sel_o(code_sel), .data_sel_o(data_sel), .ext_req_o(ext_req),
        .err_o(err), .ptr_o(ptr_val), .reset_vec_o(reset_vec)
    );

    // Monitor: compare registered outputs just after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (code_sel !== e.code || data_sel !== e.data || ext_req !== e.req || err !== e.err) begin
                n_bad++;
                $display("FAIL %s: got code=%b data=%b req=%b err=%b, expected code=%b data=%b req=%b err=%b",
                         e.tag, code_sel, data_sel, ext_req, err, e.code, e.data, e.req, e.err);
            end
        end
    end

    task automatic check(input logic [15:0] got, input logic [15:0] want, input string tag);
        n_vec++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %h, expected %h", tag, got, want);
        end
    endtask

    // Driver: one access per cycle, expected result queued
    task automatic apply(input logic [1:0] kind, input logic [15:0] addr, input logic bus,
                         input logic [2:0] ecode, input logic [2:0] edata,
                         input logic eerr, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b0; ptr_we = 1'b0; ptr_inc = 1'b0;
        acc_valid = (kind != 2'd3);
        acc_kind  = kind;
        acc_addr  = addr;
        bus_en    = bus;
        e.code = ecode; e.data = edata;
        e.req  = ecode[2] | edata[2];
        e.err  = eerr;  e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic set_cfg(input logic [3:0] v);
        apply(2'd3, 16'h0, 1'b1, 3'b000, 3'b000, 1'b0, "R14 idle during cfg write");
        cfg_we = 1'b1; cfg_wdata = v;
    endtask

    task automatic ptr_op(input logic we, input logic [2:0] wd, input logic inc,
                          input logic [2:0] want, input string tag);
        apply(2'd3, 16'h0, 1'b1, 3'b000, 3'b000, 1'b0, "R14 idle during ptr op");
        ptr_we = we; ptr_wdata = wd; ptr_inc = inc;
        apply(2'd3, 16'h0, 1'b1, 3'b000, 3'b000, 1'b0, "R14 idle after ptr op");
        check({13'd0, ptr_val}, {13'd0, want}, tag);
    endtask

    task automatic do_reset(input logic pin_in_reset, input logic pin_after);
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b0; ptr_we = 1'b0; ptr_inc = 1'b0;
        rst_n = 1'b0; ext_pin = pin_in_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; ext_pin = pin_after;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1, 1'b0);
        check({13'd0, code_sel}, 16'h0, "R14 reset code select");
        check({13'd0, data_sel}, 16'h0, "R14 reset data select");
        check({14'd0, ext_req, err}, 16'h0, "R14 reset req/err");
        check({13'd0, ptr_val}, 16'h0, "R13 reset pointer");
        check(reset_vec, 16'hF800, "R1 vector with strap high");

        // code map, strap high, boot enabled from reset
        apply(2'd0, 16'h0000, 1'b1, 3'b001, 3'b000, 1'b0, "R3 fetch 0000");
        apply(2'd0, 16'h7FFF, 1'b1, 3'b001, 3'b000, 1'b0, "R3 fetch 7FFF");
        apply(2'd0, 16'h8000, 1'b1, 3'b010, 3'b000, 1'b0, "R5 R4 fetch 8000 boot");
        apply(2'd0, 16'hF800, 1'b1, 3'b010, 3'b000, 1'b0, "R4 fetch F800 boot");
        apply(2'd3, 16'h1234, 1'b1, 3'b000, 3'b000, 1'b0, "R14 idle kind");
        check(reset_vec, 16'hF800, "R1 strap change after reset ignored");

        // data map, small size
        apply(2'd2, 16'h00FF, 1'b1, 3'b000, 3'b001, 1'b0, "R6 movx16 00FF");
        apply(2'd2, 16'h0100, 1'b1, 3'b000, 3'b100, 1'b0, "R6 R11 movx16 0100 ext");
        apply(2'd1, 16'h12FF, 1'b1, 3'b000, 3'b001, 1'b0, "R8 movx8 high byte masked");

        set_cfg(4'b1001);
        apply(2'd2, 16'h01FF, 1'b1, 3'b000, 3'b001, 1'b0, "R7 movx16 01FF");
        apply(2'd2, 16'h0200, 1'b1, 3'b000, 3'b100, 1'b0, "R7 movx16 0200 ext");

        set_cfg(4'b1011);
        apply(2'd2, 16'h0000, 1'b1, 3'b000, 3'b100, 1'b0, "R9 movx16 ext bit");
        apply(2'd1, 16'h0005, 1'b1, 3'b000, 3'b100, 1'b0, "R9 movx8 ext bit");

        set_cfg(4'b1110);
        apply(2'd2, 16'h0300, 1'b1, 3'b000, 3'b010, 1'b0, "R10 movx16 override");
        apply(2'd1, 16'h0010, 1'b1, 3'b000, 3'b010, 1'b0, "R10 movx8 override");

        set_cfg(4'b0000);
        apply(2'd0, 16'h8000, 1'b1, 3'b100, 3'b000, 1'b0, "R4 R11 fetch 8000 boot off");
        apply(2'd0, 16'h9000, 1'b0, 3'b100, 3'b000, 1'b1, "R12 fetch ext bus off");
        apply(2'd0, 16'h1000, 1'b0, 3'b001, 3'b000, 1'b0, "R12 fetch internal bus off");
        apply(2'd2, 16'h0400, 1'b0, 3'b000, 3'b100, 1'b0, "R12 movx ext bus off no err");
        apply(2'd1, 16'h0040, 1'b1, 3'b000, 3'b001, 1'b0, "R8 movx8 internal");

        // pointer select register
        ptr_op(1'b1, 3'b111, 1'b0, 3'b101, "R13 write, bit1 reads 0");
        ptr_op(1'b0, 3'b000, 1'b1, 3'b100, "R13 inc toggles select keeps flag");
        ptr_op(1'b0, 3'b000, 1'b1, 3'b101, "R13 inc toggles select again");
        ptr_op(1'b1, 3'b000, 1'b0, 3'b000, "R13 write zero");
        ptr_op(1'b0, 3'b000, 1'b1, 3'b001, "R13 inc from zero");

        // strap low at reset
        do_reset(1'b0, 1'b1);
        check(reset_vec, 16'h0000, "R1 vector with strap low");
        apply(2'd0, 16'h0000, 1'b1, 3'b100, 3'b000, 1'b0, "R2 fetch 0000 ext");
        apply(2'd0, 16'h7000, 1'b1, 3'b100, 3'b000, 1'b0, "R2 fetch 7000 ext");
        apply(2'd0, 16'hF800, 1'b1, 3'b100, 3'b000, 1'b0, "R2 R1 fetch F800 ext");
        apply(2'd2, 16'h0010, 1'b1, 3'b000, 3'b001, 1'b0, "R5 data cfg reset internal");
        apply(2'd3, 16'h0000, 1'b1, 3'b000, 3'b000, 1'b0, "R14 final idle");
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule